// File: doc/BRIEF.md
# Stack Master Election Arbiter

This block picks a master, and a backup, from the members of a switch stack. A control agent outside the block gathers one record per member. It streams those records in, one per clock cycle. Each record carries the following fields:

- the member index
- a configured mastership priority
- a flag that marks a non-default configuration
- a software priority
- an uptime count
- a 48-bit MAC address

The arbiter ranks each record as it arrives. The record flagged as last closes the round. One cycle later the winner's index and the runner-up's index appear at the outputs, where they stay until the next round or restart.

A restart discards any partial round and invalidates the outputs. Three inputs cause a restart: an explicit start pulse, a master-lost pulse (the master failed, rebooted, was removed or lost power), and a merge pulse (two stacks joined).

Top module: `stack_master_arbiter`

## Requirements
- R1: Among eligible candidates, the one with the higher configured priority (4 bits, 1 to 15) wins.
- R2: A candidate with configured priority 0 is ignored. It never becomes master or backup, and it never displaces another candidate.
- R3: At equal configured priority, a candidate whose configuration flag is 1 (non-default) beats one whose flag is 0.
- R4: When the earlier levels tie, the higher 4-bit software priority wins.
- R5: When the earlier levels tie, the larger 32-bit uptime wins.
- R6: When all other levels tie, the numerically lowest MAC address wins.
- R7: The backup output reports the member that ranks second under the same ordering. It is invalid when fewer than two candidates are eligible.
- R8: The master and backup outputs are updated at the clock edge that follows the cycle in which the record marked last is presented. During a round they keep their previous values.
- R9: If no candidate in a completed round is eligible, the no-master flag is raised and both valid flags are low.
- R10: After reset, or in the cycle after any of the start, master-lost or merge pulses, all three result flags are low. Records received before the pulse are discarded.
- R11: Between two round completions, with no restart, the results hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: begin a fresh election |
| master_lost | input | 1 | Pulse: current master is gone |
| merge_evt | input | 1 | Pulse: two stacks merged |
| cand_valid | input | 1 | A candidate record is present |
| cand_last | input | 1 | This record closes the round |
| cand_idx | input | IDX_W (4) | Member index of the record |
| cand_prio | input | 4 | Configured priority, 0 = not taking part |
| cand_cfg | input | 1 | 1 = non-default configuration |
| cand_swprio | input | 4 | Software priority |
| cand_uptime | input | 32 | Uptime count |
| cand_mac | input | 48 | MAC address |
| master_valid | output | 1 | master_idx holds a winner |
| master_idx | output | IDX_W (4) | Elected master |
| backup_valid | output | 1 | backup_idx holds a runner-up |
| backup_idx | output | IDX_W (4) | Elected backup |
| no_master | output | 1 | Last round had no eligible candidate |

## Verification
The hardest case to reach is a decision made deep in the tie-break chain while the runner-up is still being displaced. This happens when a later record must push the current best down to second place, and only the uptime or MAC level separates them. The bench draws every field from a very small range: priorities 0 to 2, single-bit software priority and uptime, and a few MAC values. As a result, ties at every level arise often across hundreds of rounds of varying length and arrival order. Directed rounds isolate each level on its own, then cover restarts in the middle of a round and rounds in which no candidate is eligible.

// File: rtl/stack_master_arbiter.sv
module stack_master_arbiter #(
  parameter int MEMBERS = 9,
  parameter int PRIO_W  = 4,
  parameter int SWP_W   = 4,
  parameter int UP_W    = 32,
  parameter int MAC_W   = 48
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     start,
  input  logic                                     master_lost,
  input  logic                                     merge_evt,
  input  logic                                     cand_valid,
  input  logic                                     cand_last,
  input  logic [((MEMBERS > 1) ? $clog2(MEMBERS) : 1)-1:0] cand_idx,
  input  logic [PRIO_W-1:0]                        cand_prio,
  input  logic                                     cand_cfg,
  input  logic [SWP_W-1:0]                         cand_swprio,
  input  logic [UP_W-1:0]                          cand_uptime,
  input  logic [MAC_W-1:0]                         cand_mac,
  output logic                                     master_valid,
  output logic [((MEMBERS > 1) ? $clog2(MEMBERS) : 1)-1:0] master_idx,
  output logic                                     backup_valid,
  output logic [((MEMBERS > 1) ? $clog2(MEMBERS) : 1)-1:0] backup_idx,
  output logic                                     no_master
);
  localparam int IDX_W = (MEMBERS > 1) ? $clog2(MEMBERS) : 1;
  localparam int KEY_W = PRIO_W + 1 + SWP_W + UP_W + MAC_W;

  // Ranking key: larger is better; MAC inverted so lowest address ranks highest.
  logic [KEY_W-1:0] cand_key;
  assign cand_key = {cand_prio, cand_cfg, cand_swprio, cand_uptime, ~cand_mac};

  logic             restart;
  logic             elig;
  assign restart = start | master_lost | merge_evt;
  assign elig    = cand_valid && (cand_prio != '0);

  logic             best_v, sec_v;
  logic [KEY_W-1:0] best_key, sec_key;
  logic [IDX_W-1:0] best_idx, sec_idx;

  logic             nb_v, ns_v;
  logic [KEY_W-1:0] nb_key, ns_key;
  logic [IDX_W-1:0] nb_idx, ns_idx;

  always_comb begin
    nb_v = best_v; nb_key = best_key; nb_idx = best_idx;
    ns_v = sec_v;  ns_key = sec_key;  ns_idx = sec_idx;
    if (elig && (!best_v || cand_key > best_key)) begin
      ns_v = best_v;  ns_key = best_key; ns_idx = best_idx;
      nb_v = 1'b1;    nb_key = cand_key; nb_idx = cand_idx;
    end else if (elig && (!sec_v || cand_key > sec_key)) begin
      ns_v = 1'b1;    ns_key = cand_key; ns_idx = cand_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_v <= 1'b0; best_key <= '0; best_idx <= '0;
      sec_v  <= 1'b0; sec_key  <= '0; sec_idx  <= '0;
      master_valid <= 1'b0; master_idx <= '0;
      backup_valid <= 1'b0; backup_idx <= '0;
      no_master    <= 1'b0;
    end else if (restart) begin
      best_v <= 1'b0; sec_v <= 1'b0;
      master_valid <= 1'b0; backup_valid <= 1'b0; no_master <= 1'b0;
    end else if (cand_valid && cand_last) begin
      best_v <= 1'b0; sec_v <= 1'b0;
      master_valid <= nb_v; master_idx <= nb_idx;
      backup_valid <= ns_v; backup_idx <= ns_idx;
      no_master    <= !nb_v;
    end else if (cand_valid) begin
      best_v <= nb_v; best_key <= nb_key; best_idx <= nb_idx;
      sec_v  <= ns_v; sec_key  <= ns_key; sec_idx  <= ns_idx;
    end
  end

  a_r7_backup_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    backup_valid |-> master_valid);

  a_r9_no_master_excl: assert property (@(posedge clk) disable iff (!rst_n)
    no_master |-> (!master_valid && !backup_valid));

  a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!master_valid && !backup_valid && !no_master));

  a_r8_round_reports: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_last && !restart) |=> (master_valid != no_master));

  a_r2_eligible_last_elects: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_last && !restart && cand_prio != '0) |=> master_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !(cand_valid && cand_last)) |=>
      ($stable(master_valid) && $stable(master_idx) && $stable(backup_valid)
       && $stable(backup_idx) && $stable(no_master)));
endmodule

// File: tb/stack_master_arbiter_tb.sv
module stack_master_arbiter_tb;
  localparam int M = 9;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, master_lost = 0, merge_evt = 0, cand_valid = 0, cand_last = 0, cand_cfg = 0;
  logic [3:0] cand_idx = 0, cand_prio = 0, cand_swprio = 0;
  logic [31:0] cand_uptime = 0;
  logic [47:0] cand_mac = 0;
  logic master_valid, backup_valid, no_master;
  logic [3:0] master_idx, backup_idx;

  always #4 clk = ~clk;

  stack_master_arbiter u_dut (.*);

  int total = 0, bad = 0;
  int p[M], c[M], s[M], id[M];
  logic [31:0] u[M];
  logic [47:0] mc[M];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic bit better(input int a, input int b);
    if (p[a] != p[b]) return p[a] > p[b];
    if (c[a] != c[b]) return c[a] > c[b];
    if (s[a] != s[b]) return s[a] > s[b];
    if (u[a] != u[b]) return u[a] > u[b];
    return mc[a] < mc[b];
  endfunction

  task automatic pulse(input int which);
    @(negedge clk);
    start = (which == 0); master_lost = (which == 1); merge_evt = (which == 2);
    @(negedge clk);
    start = 0; master_lost = 0; merge_evt = 0;
  endtask

  task automatic feed(input int n, input bit fresh);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fresh) check(!master_valid && !no_master, "R8 invalid during round", master_valid, 0);
      cand_valid = 1; cand_last = (i == n - 1);
      cand_idx = id[i][3:0]; cand_prio = p[i][3:0]; cand_cfg = c[i][0];
      cand_swprio = s[i][3:0]; cand_uptime = u[i]; cand_mac = mc[i];
    end
    @(negedge clk);
    cand_valid = 0; cand_last = 0;
  endtask

  task automatic expect_round(input int n, input string req);
    int b = -1, sc = -1;
    for (int i = 0; i < n; i++) begin
      if (p[i] == 0) continue;
      if (b < 0 || better(i, b)) begin sc = b; b = i; end
      else if (sc < 0 || better(i, sc)) sc = i;
    end
    if (b < 0) begin
      check(no_master && !master_valid && !backup_valid, "R9 no eligible", no_master, 1);
    end else begin
      check(master_valid && master_idx == id[b][3:0], req, master_idx, id[b]);
      check(!no_master, "R9 flag low", no_master, 0);
      if (sc < 0) check(!backup_valid, "R7 no backup", backup_valid, 0);
      else check(backup_valid && backup_idx == id[sc][3:0], "R7 backup", backup_idx, id[sc]);
    end
  endtask

  task automatic base(input int n);
    for (int i = 0; i < n; i++) begin
      p[i] = 1; c[i] = 0; s[i] = 0; u[i] = 0; mc[i] = 48'h100 + 48'(i); id[i] = i;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!master_valid && !backup_valid && !no_master, "R10 reset state", master_valid, 0);

    base(2); mc[0] = 1; mc[1] = 2; p[1] = 5;
    pulse(0); feed(2, 1); expect_round(2, "R1 higher priority");
    base(3); p[0] = 0; mc[0] = 0; p[2] = 0; mc[2] = 0;
    pulse(0); feed(3, 1); expect_round(3, "R2 priority zero ignored");
    check(!backup_valid, "R2 zero not backup", backup_valid, 0);
    base(2); mc[0] = 1; c[1] = 1;
    pulse(1); feed(2, 1); expect_round(2, "R3 non-default config");
    base(2); mc[0] = 1; s[1] = 3; c[0] = 0;
    pulse(2); feed(2, 1); expect_round(2, "R4 software priority");
    base(3); u[2] = 32'hFFFF_FFFF; u[1] = 7;
    pulse(0); feed(3, 1); expect_round(3, "R5 uptime");
    base(3); mc[0] = 48'hFFFF_FFFF_FFFF; mc[1] = 48'h0000_0000_0001; mc[2] = 48'h8000_0000_0000;
    pulse(0); feed(3, 1); expect_round(3, "R6 lowest MAC");
    base(4); for (int i = 0; i < 4; i++) p[i] = 0;
    pulse(0); feed(4, 1); expect_round(4, "R9 none");

    base(2); p[1] = 9; pulse(0); feed(2, 1); expect_round(2, "R11 setup");
    repeat (5) @(negedge clk);
    check(master_valid && master_idx == 1, "R11 hold", master_idx, 1);

    // R10: partial round discarded by a merge pulse
    base(2); p[0] = 15; p[1] = 15; id[0] = 7; id[1] = 8;
    @(negedge clk);
    cand_valid = 1; cand_last = 0; cand_idx = 7; cand_prio = 15; cand_cfg = 0;
    cand_swprio = 0; cand_uptime = 0; cand_mac = 5;
    @(negedge clk);
    cand_valid = 0; merge_evt = 1;
    @(negedge clk);
    merge_evt = 0;
    check(!master_valid && !backup_valid && !no_master, "R10 merge clears", master_valid, 0);
    base(2); id[0] = 3; id[1] = 4; feed(2, 1);
    check(master_valid && master_idx == 3 && backup_idx == 4, "R10 stale record dropped", master_idx, 3);

    for (int r = 0; r < 400; r++) begin
      int n = 1 + (r % M);
      for (int i = 0; i < n; i++) begin
        int h = (r * 131 + i * 71 + 17) * 2654435 + r;
        h = (h < 0) ? -h : h;
        p[i] = h % 3; c[i] = (h / 3) % 2; s[i] = (h / 7) % 2;
        u[i] = 32'((h / 11) % 2); mc[i] = 48'((h / 13) % 64 * 16 + i);
        id[i] = (i * 5 + r) % M;
      end
      pulse(r % 3); feed(n, 1); expect_round(n, "R1 sweep");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule